// File: doc/BRIEF.md
# Nine-Bit Address Match Filter

This block sits between the character-level serializers of a UART and the rest of the data path. It adds multidrop addressing, where a ninth bit on each character separates address characters (ninth bit high) from data characters (ninth bit low). On the receive side it looks at the incoming 9-bit characters and can report address characters through a status flag. When matching is on, it compares each address character against a stored receive address. It keeps only the traffic sent to that address and silently drops the rest.

On the transmit side the block can place one destination address character, taken from a stored transmit address with the ninth bit forced high, ahead of the outgoing data. The request to send that address clears itself once the character has been handed on. Data characters normally leave with the ninth bit low. A raw mode lets the host supply the ninth bit itself.

A receive address write that arrives while the receiver reports a frame in progress is held back. It takes effect only once the receiver is idle, so a frame is never judged against a half-changed address.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset the control register reads 0, the active receive address is 0, no receive character is presented, and with no transmit input valid the transmit output is not valid.
- R2: A control write takes bit 0 as nine-bit enable, bit 1 as address-match enable, bit 2 as send-address request and bit 3 as raw transmit mode, readable on `ctrl_q` the next cycle. A write with bit 0 low stores bits 1 and 2 as 0.
- R3: With nine-bit mode off, every received character is presented one cycle later with its low 8 bits and the address flag low. The ninth bit is ignored.
- R4: With nine-bit mode on and matching off, every received character is presented one cycle later, and the address flag equals its ninth bit.
- R5: With matching on, an address character equal to the active receive address is presented with the address flag high and opens the gate. An address character that differs is dropped and closes the gate.
- R6: With matching on, a data character is presented only while the gate is open. The gate is closed after reset and whenever matching is off.
- R7: A receive address write with `rx_busy` low is active the next cycle. A write while `rx_busy` is high leaves the active address unchanged until the first clock edge at which `rx_busy` is low, when the written value becomes active.
- R8: While the send-address request is set, the transmit output carries the transmit address with the ninth bit high and `tx_in_ready` is low. The request clears on the edge where `tx_out_ready` accepts that character.
- R9: A data character leaves with its ninth bit low when nine-bit mode is off, or when it is on and raw mode is off. In nine-bit raw mode the ninth bit is passed through from `tx_in_char[8]`. The low 8 bits are always passed unchanged.
- R10: A transmit address write is used by the next address character. A send-address request written with nine-bit mode off emits no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control write value |
| ctrl_q | output | 4 | Current control register |
| rar_wr | input | 1 | Receive address write strobe |
| rar_wdata | input | 8 | Receive address write value |
| rar_active | output | 8 | Receive address used for matching |
| tar_wr | input | 1 | Transmit address write strobe |
| tar_wdata | input | 8 | Transmit address write value |
| rx_busy | input | 1 | Receiver is in the middle of a frame |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 9 | Received character, bit 8 is the ninth bit |
| rx_out_valid | output | 1 | Filtered character strobe |
| rx_out_data | output | 8 | Filtered character value |
| rx_out_is_addr | output | 1 | Filtered character is an address |
| tx_in_valid | input | 1 | Outgoing data character offered |
| tx_in_char | input | 9 | Outgoing data character |
| tx_in_ready | output | 1 | Outgoing data character taken |
| tx_out_valid | output | 1 | Character offered to the transmit serializer |
| tx_out_char | output | 9 | Character to the transmit serializer |
| tx_out_ready | input | 1 | Transmit serializer takes the character |

## Verification
The bench sweeps all 512 receive characters in the plain and flagging modes, and all 256 address values in matching mode, each followed by a data character. A comparator that opened on any address, or failed to close on a mismatch, would let foreign data through right after the matching address. The bench also writes a receive address in the middle of a frame: a design that applied the write at once would show the new address while `rx_busy` is still high. On transmit it stalls the serializer while an address is pending and sweeps the ninth-bit handling in every mode. A self-clearing request that cleared without a handshake, or that leaked data ahead of the address, would show the wrong character or the wrong `ctrl_q`.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  typedef struct packed {
    logic tx_raw;
    logic send_addr;
    logic match_en;
    logic nine_en;
  } ctrl_t;

  // Clearing nine-bit mode also clears the features that depend on it.
  function automatic ctrl_t ctrl_sanitize(input logic [3:0] w);
    ctrl_t c;
    c = ctrl_t'(w);
    if (!c.nine_en) begin
      c.match_en  = 1'b0;
      c.send_addr = 1'b0;
    end
    return c;
  endfunction
endpackage

// File: rtl/mdrop_cfg.sv
module mdrop_cfg
  import mdrop_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [3:0]    cfg_wdata,
  input  logic          addr_sent,
  input  logic          rar_wr,
  input  logic [AW-1:0] rar_wdata,
  input  logic          tar_wr,
  input  logic [AW-1:0] tar_wdata,
  input  logic          rx_busy,
  output ctrl_t         ctrl,
  output logic [AW-1:0] rar_q,
  output logic [AW-1:0] tar_q,
  output logic          rar_commit
);
  logic [AW-1:0] pend_q;
  logic          pend_vld;

  assign rar_commit = !rx_busy && (rar_wr || pend_vld);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (cfg_wr) begin
      ctrl <= ctrl_sanitize(cfg_wdata);
    end else if (addr_sent) begin
      ctrl.send_addr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rar_q    <= '0;
      pend_q   <= '0;
      pend_vld <= 1'b0;
    end else if (rar_wr && !rx_busy) begin
      rar_q    <= rar_wdata;
      pend_vld <= 1'b0;
    end else if (rar_wr) begin
      pend_q   <= rar_wdata;
      pend_vld <= 1'b1;
    end else if (rar_commit) begin
      rar_q    <= pend_q;
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tar_q <= '0;
    else if (tar_wr) tar_q <= tar_wdata;
  end
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nine_en,
  input  logic          match_en,
  input  logic [AW-1:0] rar,
  input  logic          rx_valid,
  input  logic [AW:0]   rx_char,
  output logic          out_valid,
  output logic [AW-1:0] out_data,
  output logic          out_is_addr,
  output logic          gate_open,
  output logic          addr_hit,
  output logic          addr_miss
);
  logic is_addr_char;
  logic addr_eq;
  logic keep;

  function automatic logic keep_char(input logic m, input logic a,
                                     input logic eq, input logic g);
    if (!m) return 1'b1;
    return a ? eq : g;
  endfunction

  assign is_addr_char = nine_en && rx_char[AW];
  assign addr_eq      = (rx_char[AW-1:0] == rar);
  assign addr_hit     = rx_valid && match_en && is_addr_char && addr_eq;
  assign addr_miss    = rx_valid && match_en && is_addr_char && !addr_eq;
  assign keep         = keep_char(match_en, is_addr_char, addr_eq, gate_open);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_is_addr <= 1'b0;
      gate_open   <= 1'b0;
    end else begin
      out_valid   <= rx_valid && keep;
      out_data    <= rx_char[AW-1:0];
      out_is_addr <= is_addr_char;
      if (!match_en)      gate_open <= 1'b0;
      else if (addr_hit)  gate_open <= 1'b1;
      else if (addr_miss) gate_open <= 1'b0;
    end
  end
endmodule

// File: rtl/mdrop_tx.sv
module mdrop_tx #(
  parameter int AW = 8
) (
  input  logic          nine_en,
  input  logic          send_addr,
  input  logic          tx_raw,
  input  logic [AW-1:0] tar,
  input  logic          tx_in_valid,
  input  logic [AW:0]   tx_in_char,
  output logic          tx_in_ready,
  output logic          tx_out_valid,
  output logic [AW:0]   tx_out_char,
  input  logic          tx_out_ready,
  output logic          addr_sent
);
  function automatic logic [AW:0] map_data(input logic nine, input logic raw,
                                           input logic [AW:0] c);
    return {nine && raw && c[AW], c[AW-1:0]};
  endfunction

  logic addr_pend;

  assign addr_pend    = send_addr && nine_en;
  assign tx_out_valid = addr_pend || tx_in_valid;
  assign tx_out_char  = addr_pend ? {1'b1, tar} : map_data(nine_en, tx_raw, tx_in_char);
  assign tx_in_ready  = tx_out_ready && !addr_pend;
  assign addr_sent    = addr_pend && tx_out_ready;
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
  import mdrop_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [3:0]    cfg_wdata,
  output logic [3:0]    ctrl_q,
  input  logic          rar_wr,
  input  logic [AW-1:0] rar_wdata,
  output logic [AW-1:0] rar_active,
  input  logic          tar_wr,
  input  logic [AW-1:0] tar_wdata,
  input  logic          rx_busy,
  input  logic          rx_valid,
  input  logic [AW:0]   rx_char,
  output logic          rx_out_valid,
  output logic [AW-1:0] rx_out_data,
  output logic          rx_out_is_addr,
  input  logic          tx_in_valid,
  input  logic [AW:0]   tx_in_char,
  output logic          tx_in_ready,
  output logic          tx_out_valid,
  output logic [AW:0]   tx_out_char,
  input  logic          tx_out_ready
);
  ctrl_t         ctrl;
  logic [AW-1:0] tar_q;
  logic          addr_sent;
  logic          rar_commit;
  logic          gate_open;
  logic          addr_hit;
  logic          addr_miss;

  assign ctrl_q = ctrl;

  mdrop_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .addr_sent(addr_sent),
    .rar_wr(rar_wr), .rar_wdata(rar_wdata),
    .tar_wr(tar_wr), .tar_wdata(tar_wdata),
    .rx_busy(rx_busy),
    .ctrl(ctrl), .rar_q(rar_active), .tar_q(tar_q), .rar_commit(rar_commit)
  );

  mdrop_rx #(.AW(AW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .nine_en(ctrl.nine_en), .match_en(ctrl.match_en), .rar(rar_active),
    .rx_valid(rx_valid), .rx_char(rx_char),
    .out_valid(rx_out_valid), .out_data(rx_out_data), .out_is_addr(rx_out_is_addr),
    .gate_open(gate_open), .addr_hit(addr_hit), .addr_miss(addr_miss)
  );

  mdrop_tx #(.AW(AW)) u_tx (
    .nine_en(ctrl.nine_en), .send_addr(ctrl.send_addr), .tx_raw(ctrl.tx_raw),
    .tar(tar_q),
    .tx_in_valid(tx_in_valid), .tx_in_char(tx_in_char), .tx_in_ready(tx_in_ready),
    .tx_out_valid(tx_out_valid), .tx_out_char(tx_out_char),
    .tx_out_ready(tx_out_ready), .addr_sent(addr_sent)
  );
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [3:0]    ctrl_q,
  input logic [AW-1:0] rar_active,
  input logic          rx_busy,
  input logic          rx_valid,
  input logic [AW:0]   rx_char,
  input logic          rx_out_valid,
  input logic          rx_out_is_addr,
  input logic          gate_open,
  input logic          tx_in_ready,
  input logic          tx_out_valid,
  input logic [AW:0]   tx_out_char,
  input logic          tx_out_ready,
  input logic          rar_commit
);
  // R2
  nine_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> (ctrl_q[2:1] == 2'b00));

  // R3
  no_flag_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && !$past(ctrl_q[0])) |-> !rx_out_is_addr);

  // R5
  miss_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && ctrl_q[1] && rx_char[AW] && (rx_char[AW-1:0] != rar_active)) |=> !rx_out_valid);

  // R6
  closed_gate_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && ctrl_q[1] && !rx_char[AW] && !gate_open) |=> !rx_out_valid);

  // R7
  rar_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rar_active) |-> !$past(rx_busy));

  // R7
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rar_commit |-> !rx_busy);

  // R8
  addr_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2] && tx_out_valid && tx_out_ready && !cfg_wr) |=> !ctrl_q[2]);

  // R8
  ready_needs_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_ready |-> tx_out_ready);

  // R9
  plain_tx_ninth_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !ctrl_q[0]) |-> !tx_out_char[AW]);
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.AW(AW)) u_chk (.*);

// File: tb/mdrop_addr_filter_bench.sv
`timescale 1ns/1ps
module mdrop_addr_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] ctrl_q;
  logic       rar_wr = 1'b0;
  logic [7:0] rar_wdata = '0;
  logic [7:0] rar_active;
  logic       tar_wr = 1'b0;
  logic [7:0] tar_wdata = '0;
  logic       rx_busy = 1'b0;
  logic       rx_valid = 1'b0;
  logic [8:0] rx_char = '0;
  logic       rx_out_valid;
  logic [7:0] rx_out_data;
  logic       rx_out_is_addr;
  logic       tx_in_valid = 1'b0;
  logic [8:0] tx_in_char = '0;
  logic       tx_in_ready;
  logic       tx_out_valid;
  logic [8:0] tx_out_char;
  logic       tx_out_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mdrop_addr_filter u_mdrop_addr_filter (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wr_rar(input logic [7:0] v);
    @(negedge clk); rar_wr = 1'b1; rar_wdata = v;
    @(negedge clk); rar_wr = 1'b0;
  endtask

  task automatic rx_send(input string req, input logic [8:0] c, input logic ev,
                         input logic [7:0] ed, input logic ef);
    @(negedge clk); rx_valid = 1'b1; rx_char = c;
    @(negedge clk); rx_valid = 1'b0;
    chk(req, {31'd0, rx_out_valid}, {31'd0, ev});
    if (ev) begin
      chk(req, {24'd0, rx_out_data}, {24'd0, ed});
      chk(req, {31'd0, rx_out_is_addr}, {31'd0, ef});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic gate;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {28'd0, ctrl_q}, 32'd0);
    chk("R1", {24'd0, rar_active}, 32'd0);
    chk("R1", {31'd0, rx_out_valid}, 32'd0);
    chk("R1", {31'd0, tx_out_valid}, 32'd0);

    // R2 control bit positions and sanitising
    wr_ctrl(4'b0110);
    chk("R2", {28'd0, ctrl_q}, 32'd0);
    wr_ctrl(4'b1011);
    chk("R2", {28'd0, ctrl_q}, 32'hB);
    wr_ctrl(4'b1110);
    chk("R2", {28'd0, ctrl_q}, 32'h8);

    // R6 matching armed but gate closed: data dropped
    wr_rar(8'h5A);
    wr_ctrl(4'b0011);
    rx_send("R6", 9'h011, 1'b0, 8'h00, 1'b0);

    // R5 R6 sweep all addresses, each followed by a data char
    for (int a = 0; a < 256; a++) begin
      gate = (a == 8'h5A);
      rx_send("R5", {1'b1, 8'(a)}, gate, 8'(a), 1'b1);
      rx_send("R6", {1'b0, 8'(a) ^ 8'hFF}, gate, 8'(a) ^ 8'hFF, 1'b0);
    end
    // R6 disabling matching closes the gate
    rx_send("R5", 9'h15A, 1'b1, 8'h5A, 1'b1);
    wr_ctrl(4'b0001);
    wr_ctrl(4'b0011);
    rx_send("R6", 9'h022, 1'b0, 8'h00, 1'b0);

    // R3 nine-bit off: ninth bit ignored
    wr_ctrl(4'b0000);
    for (int c = 0; c < 512; c++) rx_send("R3", 9'(c), 1'b1, 8'(c), 1'b0);
    // R4 nine-bit on, no matching: flag is ninth bit
    wr_ctrl(4'b0001);
    for (int c = 0; c < 512; c++) rx_send("R4", 9'(c), 1'b1, 8'(c), c[8]);

    // R7 receive address write held during a frame
    @(negedge clk); rx_busy = 1'b1;
    wr_rar(8'h33);
    repeat (3) @(negedge clk);
    chk("R7", {24'd0, rar_active}, 32'h5A);
    rx_busy = 1'b0;
    @(negedge clk);
    chk("R7", {24'd0, rar_active}, 32'h33);
    @(negedge clk); rar_wr = 1'b1; rar_wdata = 8'hC4;
    @(negedge clk); rar_wr = 1'b0;
    chk("R7", {24'd0, rar_active}, 32'hC4);

    // R9 transmit ninth-bit handling, all three modes
    tx_in_valid = 1'b1;
    for (int m = 0; m < 3; m++) begin
      wr_ctrl(m == 0 ? 4'b0000 : (m == 1 ? 4'b0001 : 4'b1001));
      for (int c = 0; c < 512; c++) begin
        @(negedge clk); tx_in_char = 9'(c);
        #1;
        chk("R9", {23'd0, tx_out_char},
            {23'd0, (m == 2) ? c[8] : 1'b0, 8'(c)});
      end
    end

    // R10 R8 address insertion
    tx_out_ready = 1'b0;
    tx_in_char = 9'h03C;
    @(negedge clk); tar_wr = 1'b1; tar_wdata = 8'hA7;
    @(negedge clk); tar_wr = 1'b0;
    wr_ctrl(4'b0101);
    #1;
    chk("R10", {23'd0, tx_out_char}, 32'h1A7);
    chk("R8", {31'd0, tx_in_ready}, 32'd0);
    @(negedge clk); #1;
    chk("R8", {28'd0, ctrl_q}, 32'h5);
    tx_out_ready = 1'b1;
    #1;
    chk("R8", {23'd0, tx_out_char}, 32'h1A7);
    chk("R8", {31'd0, tx_in_ready}, 32'd0);
    @(negedge clk); #1;
    chk("R8", {28'd0, ctrl_q}, 32'h1);
    chk("R8", {23'd0, tx_out_char}, 32'h03C);
    chk("R8", {31'd0, tx_in_ready}, 32'd1);
    // R10 request with nine-bit off emits no address
    wr_ctrl(4'b0100);
    #1;
    chk("R10", {23'd0, tx_out_char}, 32'h03C);
    chk("R10", {28'd0, ctrl_q}, 32'd0);
    tx_in_valid = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule